// File: doc/BRIEF.md
# Color Table Host Access Controller

This block sits between an 8-bit host register port and a 256-entry color table whose words are 24 bits wide: 8 bits of red, 8 of green and 8 of blue. The host never touches the table directly. It loads an address register and then moves bytes through a three-byte holding register. Writes gather red, green and blue and commit the whole word once blue arrives. Reads prefetch a word into the holding register and hand it out one byte at a time. After every word the address moves to the next entry, and it wraps from the last entry back to entry 0.

A second, independent read port serves the display path. A display index goes in and the formatted 24-bit color comes out one clock later. A narrow-mode input selects 6-bit compatibility. The table still keeps all 8 bits of each color. Host readback clears the two upper bits of each byte. Display output moves the low six bits of each color to the top and puts zeros in the two low bits.

The host sequencer has four named states. IDLE accepts strobes. COMMIT writes the gathered word and advances the address. FETCH issues a table read at the address register. CAPTURE loads the holding register and advances the address. The transitions are:
- IDLE to COMMIT on a data write of the blue byte.
- IDLE to FETCH on a read-address load.
- IDLE to FETCH on a data read of the blue byte.
- FETCH to CAPTURE always.
- COMMIT to IDLE and CAPTURE to IDLE always.

Every other strobe keeps IDLE.

Top module: `palctl_top`

## Requirements
- R1: After reset the address register reads 0, the byte counter points at red and the sequencer is in IDLE. A host read with host_sel = 2'b00 (write-address select) or 2'b10 (read-address select) returns the current address on host_rdata.
- R2: A write strobe with host_sel = 2'b00 loads the address. Three data writes with host_sel = 2'b01 then supply red, green and blue. After the blue byte the word {red[23:16], green[15:8], blue[7:0]} is stored at that address and the address increments by one.
- R3: A write strobe with host_sel = 2'b10 loads the address, copies that entry into the holding register and increments the address.
- R4: Data reads (host_rd with host_sel = 2'b01) return red, green, then blue, with host_rdata valid while the strobe is high. After the blue read the entry at the current address is fetched into the holding register and the address increments again.
- R5: The address wraps from 255 to 0 on both the write path and the read path.
- R6: With narrow_mode = 1, data readback forces bits 7:6 of each byte to 0. The table keeps all 8 bits, and a later readback with narrow_mode = 0 returns them unchanged.
- R7: With narrow_mode = 1, each color of disp_rgb equals the low six bits of the stored byte shifted up by two, with the two low bits 0. With narrow_mode = 0 the stored byte appears as is.
- R8: disp_rgb reflects the entry selected by disp_index one clock edge earlier. If a host commit and a display read hit the same entry on the same edge, the display gets the old word.
- R9: Loading either address register resets the byte counter to red, so a partial red/green/blue sequence is discarded.
- R10: Host strobes that arrive while the sequencer is in COMMIT, FETCH or CAPTURE are ignored. host_sel = 2'b11 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_sel | input | 2 | Register select: 00 write address, 01 data, 10 read address, 11 unused |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte: the address, or the current holding byte |
| narrow_mode | input | 1 | 6-bit compatibility mode |
| disp_index | input | 8 | Display lookup index |
| disp_rgb | output | 24 | Formatted display color {red, green, blue} |

## Verification
The assertions assume that host_wr and host_rd never rise together. They also assume that each data-register strobe lasts one cycle, so a single strobe never counts as two byte transfers. The stimulus raises one strobe for one clock and then leaves at least three idle cycles, which keeps every operation apart except where R10 deliberately lands a strobe inside FETCH. The R8 collision check is timed by counting edges from the blue write: the commit edge is the second edge after the strobe is raised.

// File: rtl/palctl_pkg.sv
`timescale 1ns/1ps
package palctl_pkg;

    typedef enum logic [1:0] {
        SEL_WADDR = 2'b00,
        SEL_DATA  = 2'b01,
        SEL_RADDR = 2'b10,
        SEL_NONE  = 2'b11
    } host_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_COMMIT  = 2'b01,
        ST_FETCH   = 2'b10,
        ST_CAPTURE = 2'b11
    } host_state_e;

endpackage

// File: rtl/palctl_ram.sv
`timescale 1ns/1ps
module palctl_ram #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [WORD_W-1:0] host_q,
    input  logic [ADDR_W-1:0] disp_raddr,
    output logic [WORD_W-1:0] disp_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Both read ports sample the array before this edge's write lands.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        host_q <= mem[host_raddr];
        disp_q <= mem[disp_raddr];
    end

endmodule

// File: rtl/palctl_disp_fmt.sv
`timescale 1ns/1ps
module palctl_disp_fmt #(
    parameter int DATA_W   = 8,
    parameter int NUM_CH   = 3,
    parameter int NARROW_W = 6
) (
    input  logic [DATA_W*NUM_CH-1:0] word_in,
    input  logic                     narrow,
    output logic [DATA_W*NUM_CH-1:0] word_out
);
    localparam int SHIFT = DATA_W - NARROW_W;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic [DATA_W-1:0] lane_in;
        assign lane_in = word_in[c*DATA_W +: DATA_W];
        assign word_out[c*DATA_W +: DATA_W] =
            narrow ? {lane_in[NARROW_W-1:0], {SHIFT{1'b0}}} : lane_in;
    end

endmodule

// File: rtl/palctl_host_fsm.sv
`timescale 1ns/1ps
module palctl_host_fsm
    import palctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int NUM_CH   = 3,
    parameter int NARROW_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic                     rd_stb,
    input  logic [1:0]               sel,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     narrow,
    input  logic [DATA_W*NUM_CH-1:0] ram_q,
    output logic                     ram_we,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [DATA_W*NUM_CH-1:0] ram_wdata,
    output logic [DATA_W-1:0]        rdata,
    output host_state_e              state_o,
    output logic [$clog2(NUM_CH)-1:0] cnt_o
);
    localparam int WORD_W = DATA_W * NUM_CH;
    localparam int CNT_W  = $clog2(NUM_CH);
    localparam int SHIFT  = DATA_W - NARROW_W;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_CH - 1);
    localparam logic [DATA_W-1:0] NARROW_MASK = {{SHIFT{1'b0}}, {NARROW_W{1'b1}}};

    host_state_e       state_q, state_d;
    host_sel_e         sel_e;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] hold_q;
    logic              wr_go, rd_go, last_byte;
    logic [DATA_W-1:0] hold_byte;

    assign sel_e     = host_sel_e'(sel);
    assign wr_go     = wr_stb;
    assign rd_go     = rd_stb && !wr_stb;
    assign last_byte = (cnt_q == LAST_CNT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_go && sel_e == SEL_DATA && last_byte) begin
                    state_d = ST_COMMIT;
                end else if (wr_go && sel_e == SEL_RADDR) begin
                    state_d = ST_FETCH;
                end else if (rd_go && sel_e == SEL_DATA && last_byte) begin
                    state_d = ST_FETCH;
                end
            end
            ST_COMMIT:  state_d = ST_IDLE;
            ST_FETCH:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Address, byte counter and holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_go) begin
                        unique case (sel_e)
                            SEL_WADDR, SEL_RADDR: begin
                                addr_q <= ADDR_W'(wdata);
                                cnt_q  <= '0;
                            end
                            SEL_DATA: begin
                                for (int c = 0; c < NUM_CH; c++) begin
                                    if (c == int'(cnt_q)) begin
                                        hold_q[(NUM_CH-1-c)*DATA_W +: DATA_W] <= wdata;
                                    end
                                end
                                cnt_q <= last_byte ? '0 : cnt_q + CNT_W'(1);
                            end
                            default: ;
                        endcase
                    end else if (rd_go && sel_e == SEL_DATA) begin
                        cnt_q <= last_byte ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                ST_COMMIT: begin
                    addr_q <= addr_q + ADDR_W'(1);
                end
                ST_FETCH: ;
                ST_CAPTURE: begin
                    hold_q <= ram_q;
                    addr_q <= addr_q + ADDR_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        hold_byte = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c == int'(cnt_q)) begin
                hold_byte = hold_q[(NUM_CH-1-c)*DATA_W +: DATA_W];
            end
        end
    end

    // Outputs
    always_comb begin
        ram_we    = (state_q == ST_COMMIT);
        ram_addr  = addr_q;
        ram_wdata = hold_q;
        state_o   = state_q;
        cnt_o     = cnt_q;
        if (sel_e == SEL_DATA) begin
            rdata = narrow ? (hold_byte & NARROW_MASK) : hold_byte;
        end else if (sel_e == SEL_NONE) begin
            rdata = '0;
        end else begin
            rdata = DATA_W'(addr_q);
        end
    end

endmodule

// File: rtl/palctl_top.sv
`timescale 1ns/1ps
module palctl_top
    import palctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int NUM_CH   = 3,
    parameter int NARROW_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [1:0]               host_sel,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    input  logic                     narrow_mode,
    input  logic [ADDR_W-1:0]        disp_index,
    output logic [DATA_W*NUM_CH-1:0] disp_rgb
);
    localparam int WORD_W = DATA_W * NUM_CH;
    localparam int CNT_W  = $clog2(NUM_CH);

    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] host_q;
    logic [WORD_W-1:0] disp_q;
    host_state_e       fsm_state;
    logic [CNT_W-1:0]  fsm_cnt;

    palctl_host_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .NARROW_W(NARROW_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (host_wr),
        .rd_stb   (host_rd),
        .sel      (host_sel),
        .wdata    (host_wdata),
        .narrow   (narrow_mode),
        .ram_q    (host_q),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata),
        .rdata    (host_rdata),
        .state_o  (fsm_state),
        .cnt_o    (fsm_cnt)
    );

    palctl_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk       (clk),
        .we        (ram_we),
        .waddr     (ram_addr),
        .wdata     (ram_wdata),
        .host_raddr(ram_addr),
        .host_q    (host_q),
        .disp_raddr(disp_index),
        .disp_q    (disp_q)
    );

    palctl_disp_fmt #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .NARROW_W(NARROW_W)) u_fmt (
        .word_in (disp_q),
        .narrow  (narrow_mode),
        .word_out(disp_rgb)
    );

endmodule

// File: rtl/palctl_chk.sv
`timescale 1ns/1ps
module palctl_chk
    import palctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int NUM_CH   = 3,
    parameter int NARROW_W = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input host_state_e               state,
    input logic [ADDR_W-1:0]         addr,
    input logic [$clog2(NUM_CH)-1:0] cnt,
    input logic                      ram_we,
    input logic [1:0]                host_sel,
    input logic [DATA_W-1:0]         host_rdata,
    input logic                      narrow_mode,
    input logic [DATA_W*NUM_CH-1:0]  disp_rgb
);
    localparam int SHIFT = DATA_W - NARROW_W;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (addr == '0 && cnt == '0 && state == ST_IDLE));

    // R2
    commit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> addr == $past(addr) + ADDR_W'(1));

    // R3
    capture_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CAPTURE |=> state == ST_IDLE);

    // R4
    fetch_then_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> state == ST_CAPTURE);

    // R9
    counter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < NUM_CH);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH || state == ST_COMMIT) |=> $stable(cnt));

    // R6
    narrow_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_mode && host_sel == 2'b01) |-> host_rdata[DATA_W-1:NARROW_W] == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane_chk
        // R7
        narrow_display_chk: assert property (@(posedge clk) disable iff (!rst_n)
            narrow_mode |-> disp_rgb[c*DATA_W +: SHIFT] == '0);
    end

endmodule

bind palctl_top palctl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .NARROW_W(NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (fsm_state),
    .addr       (ram_addr),
    .cnt        (fsm_cnt),
    .ram_we     (ram_we),
    .host_sel   (host_sel),
    .host_rdata (host_rdata),
    .narrow_mode(narrow_mode),
    .disp_rgb   (disp_rgb)
);

// File: tb/tb_palctl_top.sv
`timescale 1ns/1ps
module tb_palctl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_sel = 2'b00;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        narrow_mode = 1'b0;
    logic [7:0]  disp_index = '0;
    logic [23:0] disp_rgb;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_skip = 1'b0;
    bit   done     = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    palctl_top dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .narrow_mode(narrow_mode), .disp_index(disp_index), .disp_rgb(disp_rgb)
    );

    localparam logic [1:0] WA = 2'b00, DT = 2'b01, RA = 2'b10, NA = 2'b11;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected byte per data read strobe
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (host_rd && host_sel == DT && !mon_skip) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected read actual=%0h expected=none", host_rdata);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (host_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s actual=%0h expected=%0h", t, host_rdata, e);
                    end
                end
            end
        end
    end

    task automatic host_op(input bit wr, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = wr; host_rd = !wr; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_rgb(input logic [7:0] a, input logic [23:0] w);
        host_op(1'b1, WA, a);
        host_op(1'b1, DT, w[23:16]);
        host_op(1'b1, DT, w[15:8]);
        host_op(1'b1, DT, w[7:0]);
    endtask

    task automatic read_expect(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        host_op(1'b0, DT, 8'h00);
    endtask

    task automatic check_addr(input logic [7:0] e, input string t);
        host_sel = WA;
        #1;
        check(t, 32'(host_rdata), 32'(e));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: address reads 0 after reset
        check_addr(8'h00, "R1 reset address");
        host_sel = RA; #1;
        check("R1 read-address select", 32'(host_rdata), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: write two words and see the address advance
        write_rgb(8'd5, 24'h112233);
        host_op(1'b1, DT, 8'h44); host_op(1'b1, DT, 8'h55); host_op(1'b1, DT, 8'h66);
        check_addr(8'd7, "R2 address after two commits");

        // R3: read-address load prefetches and increments
        host_op(1'b1, RA, 8'd5);
        check_addr(8'd6, "R3 address after load");
        // R4: red, green, blue order then next word
        read_expect(8'h11, "R4 red"); read_expect(8'h22, "R4 green"); read_expect(8'h33, "R4 blue");
        check_addr(8'd7, "R4 address after blue read");
        read_expect(8'h44, "R4 next red"); read_expect(8'h55, "R4 next green"); read_expect(8'h66, "R4 next blue");

        // R5: wrap on write and read paths
        write_rgb(8'd0, 24'h0a0b0c);
        write_rgb(8'd255, 24'hAABBCC);
        check_addr(8'd0, "R5 write wrap");
        host_op(1'b1, RA, 8'd255);
        check_addr(8'd0, "R5 read wrap");
        read_expect(8'hAA, "R5 red"); read_expect(8'hBB, "R5 green"); read_expect(8'hCC, "R5 blue");
        check_addr(8'd1, "R5 address after wrap fetch");
        read_expect(8'h0a, "R5 entry 0 red");

        // R6: narrow readback masks, storage keeps 8 bits
        write_rgb(8'd10, 24'hF1F2F3);
        narrow_mode = 1'b1;
        host_op(1'b1, RA, 8'd10);
        read_expect(8'h31, "R6 narrow red"); read_expect(8'h32, "R6 narrow green"); read_expect(8'h33, "R6 narrow blue");
        narrow_mode = 1'b0;
        host_op(1'b1, RA, 8'd10);
        read_expect(8'hF1, "R6 full red"); read_expect(8'hF2, "R6 full green"); read_expect(8'hF3, "R6 full blue");

        // R7: display formatting
        @(negedge clk); disp_index = 8'd10; narrow_mode = 1'b1;
        @(negedge clk);
        check("R7 narrow display", 32'(disp_rgb), 32'hC4C8CC);
        narrow_mode = 1'b0; #1;
        check("R7 full display", 32'(disp_rgb), 32'hF1F2F3);

        // R8: one-edge latency and old data on collision
        write_rgb(8'd20, 24'h010203);
        @(negedge clk); disp_index = 8'd20;
        @(negedge clk);
        check("R8 latency", 32'(disp_rgb), 32'h010203);
        host_op(1'b1, WA, 8'd20);
        host_op(1'b1, DT, 8'h04);
        host_op(1'b1, DT, 8'h05);
        @(negedge clk); host_wr = 1'b1; host_sel = DT; host_wdata = 8'h06;
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk);
        check("R8 collision old word", 32'(disp_rgb), 32'h010203);
        @(negedge clk);
        check("R8 new word next edge", 32'(disp_rgb), 32'h040506);

        // R9: address load discards partial sequence
        host_op(1'b1, WA, 8'd30);
        host_op(1'b1, DT, 8'h77);
        host_op(1'b1, WA, 8'd30);
        host_op(1'b1, DT, 8'h01); host_op(1'b1, DT, 8'h02); host_op(1'b1, DT, 8'h03);
        host_op(1'b1, RA, 8'd30);
        read_expect(8'h01, "R9 red"); read_expect(8'h02, "R9 green"); read_expect(8'h03, "R9 blue");

        // R10: strobe during FETCH ignored, unused select ignored
        @(negedge clk); host_wr = 1'b1; host_sel = RA; host_wdata = 8'd5;
        @(negedge clk); host_wr = 1'b0; host_rd = 1'b1; host_sel = DT; mon_skip = 1'b1;
        @(negedge clk); host_rd = 1'b0; mon_skip = 1'b0;
        repeat (3) @(negedge clk);
        host_op(1'b1, NA, 8'h99);
        check_addr(8'd6, "R10 address unchanged");
        read_expect(8'h11, "R10 red"); read_expect(8'h22, "R10 green"); read_expect(8'h33, "R10 blue");

        check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule